// File: doc/BRIEF.md
# Reservation Monitor for Atomic Load/Store Pairs

This block holds the single reservation that a one-hart core needs to build an atomic read-modify-write out of a reserving load and a conditional store. A reserving load records the word address it read and arms the reservation. A later conditional store writes memory only if the reservation is still armed and its address is the reserved one. The outcome appears on a registered one-bit flag that the core can test.

Each cycle the core may present one operation: a reserving load, a conditional store or a plain store. The address of that operation is formed inside the block as a base plus a sign-extended offset. For stores, the block drives the memory write strobe, the byte-lane enables, the address and the data. For a conditional store the write strobe is gated by the outcome of the check. A plain store of any width to the reserved word cancels the reservation. Every conditional store disarms it, whether it succeeds or fails.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset `resv_valid` is 0, `resv_addr` is 0 and `sc_flag` is 0.
- R2: A reserving load (`op_valid`=1, `op_kind`=1) makes `resv_valid` 1 and `resv_addr` equal to its effective address from the next cycle on.
- R3: The effective address, driven on `mem_addr` in the same cycle, is `base_addr` plus `offset` sign-extended to the address width.
- R4: For a conditional store (`op_kind`=2), `sc_flag` becomes 1 in the next cycle when `resv_valid` was 1 and the effective address equals `resv_addr` in full. Otherwise it becomes 0.
- R5: During a conditional store, `mem_we` is 1 in the same cycle only when the check of R4 passes, and `mem_be` is then 4'b1111.
- R6: Any conditional store, whether it passes or fails, leaves `resv_valid` at 0 in the next cycle.
- R7: A plain store (`op_kind`=3) makes `resv_valid` 0 when its effective address with bits [1:0] forced to zero equals `resv_addr`. Otherwise the reservation is unchanged.
- R8: A plain store always drives `mem_we`=1. `st_size` 0 selects one lane (`mem_be` = 1 << addr[1:0]), 1 selects two lanes (`mem_be` = 3 << {addr[1],0}), and 2 or 3 select all four lanes.
- R9: `sc_flag` changes only at the edge that ends a conditional store and holds its value across all other operations.
- R10: With `op_valid`=0, or `op_kind`=0, `mem_we` is 0 and neither the reservation nor `sc_flag` changes.
- R11: `mem_wdata` carries `st_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 0 none, 1 reserving load, 2 conditional store, 3 plain store |
| st_size | input | 2 | Plain store width: 0 byte, 1 halfword, 2/3 word |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed offset |
| st_data | input | 32 | Store data |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Write data to memory |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane enables |
| sc_flag | output | 1 | Conditional store outcome, registered |
| resv_valid | output | 1 | Reservation armed |
| resv_addr | output | 32 | Reserved address |

## Verification
Two things happen at the same edge and are the main concern. First, the edge that ends a conditional store also records its outcome on the flag and disarms the reservation. Second, a plain store has to be compared with the reservation in the same cycle in which it writes memory. The bench exercises both with back-to-back sequences: load then conditional store, a second conditional store straight after a successful one, and a reserving load straight after a cancelling store. It also draws addresses from a small pool so that random traffic hits the reserved word often. Every cycle, the write strobe and lane enables are compared with a reference model in the bench, and the flag and reservation are compared one cycle later.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        st_size,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [31:0]       st_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              mem_we,
  output logic [3:0]        mem_be,
  output logic              sc_flag,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_addr
);
  localparam logic [1:0] K_LOAD = 2'd1;
  localparam logic [1:0] K_COND = 2'd2;
  localparam logic [1:0] K_PLAIN = 2'd3;

  logic [ADDR_W-1:0] eff;
  logic is_load, is_cond, is_plain, cond_hit, plain_hit;
  logic [3:0] plain_be;

  assign eff       = base_addr + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
  assign is_load   = op_valid && op_kind == K_LOAD;
  assign is_cond   = op_valid && op_kind == K_COND;
  assign is_plain  = op_valid && op_kind == K_PLAIN;
  assign cond_hit  = resv_valid && eff == resv_addr;
  assign plain_hit = resv_valid && {eff[ADDR_W-1:2], 2'b00} == resv_addr;

  always_comb begin
    case (st_size)
      2'd0:    plain_be = 4'b0001 << eff[1:0];
      2'd1:    plain_be = 4'b0011 << {eff[1], 1'b0};
      default: plain_be = 4'b1111;
    endcase
  end

  assign mem_addr  = eff;
  assign mem_wdata = st_data;
  assign mem_we    = is_plain || (is_cond && cond_hit);
  assign mem_be    = is_cond ? 4'b1111 : (is_plain ? plain_be : 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_addr  <= '0;
      sc_flag    <= 1'b0;
    end else begin
      if (is_cond) sc_flag <= cond_hit;
      if (is_load) begin
        resv_valid <= 1'b1;
        resv_addr  <= eff;
      end else if (is_cond || (is_plain && plain_hit)) begin
        resv_valid <= 1'b0;
      end
    end
  end

  a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> resv_valid && resv_addr == $past(mem_addr));
  a_r6_cond_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    is_cond |=> !resv_valid);
  a_r5_write_means_success: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && mem_we) |=> sc_flag);
  a_r4_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cond && !resv_valid) |=> !sc_flag);
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cond |=> $stable(sc_flag));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(resv_valid) && $stable(resv_addr));
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !mem_we);
  a_r7_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_plain && {mem_addr[ADDR_W-1:2], 2'b00} != resv_addr) |=> $stable(resv_valid));
endmodule

// File: tb/sim_lrsc_monitor.sv
module sim_lrsc_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0, st_size = 2'd0;
  logic [31:0] base_addr = '0, st_data = '0;
  logic [15:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, resv_addr;
  logic mem_we, sc_flag, resv_valid;
  logic [3:0] mem_be;

  int checks = 0, fails = 0;
  bit m_v = 1'b0, m_f = 1'b0;
  logic [31:0] m_a = '0;

  always #2 clk = ~clk;

  lrsc_monitor u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .st_size(st_size), .base_addr(base_addr), .offset(offset), .st_data(st_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_be(mem_be),
    .sc_flag(sc_flag), .resv_valid(resv_valid), .resv_addr(resv_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_eff(logic [31:0] b, logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic logic [3:0] f_be(logic v, logic [1:0] k, logic [1:0] sz, logic [31:0] e);
    if (!v || k == 2'd0 || k == 2'd1) return 4'b0000;
    if (k == 2'd2) return 4'b1111;
    case (sz)
      2'd0: return 4'b0001 << e[1:0];
      2'd1: return 4'b0011 << {e[1], 1'b0};
      default: return 4'b1111;
    endcase
  endfunction

  task automatic op(logic v, logic [1:0] k, logic [1:0] sz, logic [31:0] b, logic [15:0] o, logic [31:0] d);
    logic [31:0] e;
    bit hit;
    chk("R2/R6/R7 resv_valid", {31'd0, resv_valid}, {31'd0, m_v});
    chk("R2 resv_addr", resv_addr, m_a);
    chk("R4/R9 sc_flag", {31'd0, sc_flag}, {31'd0, m_f});
    op_valid = v; op_kind = k; st_size = sz; base_addr = b; offset = o; st_data = d;
    e = f_eff(b, o);
    hit = m_v && e == m_a;
    #1;
    chk("R3 mem_addr", mem_addr, e);
    chk("R11 mem_wdata", mem_wdata, d);
    chk("R5/R8/R10 mem_we", {31'd0, mem_we},
        {31'd0, v && (k == 2'd3 || (k == 2'd2 && hit))});
    chk("R5/R8 mem_be", {28'd0, mem_be}, {28'd0, f_be(v, k, sz, e)});
    @(posedge clk);
    if (v) begin
      case (k)
        2'd1: begin m_v = 1'b1; m_a = e; end
        2'd2: begin m_f = hit; m_v = 1'b0; end
        2'd3: if ({e[31:2], 2'b00} == m_a) m_v = 1'b0;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 resv_valid", {31'd0, resv_valid}, 32'd0);
    chk("R1 resv_addr", resv_addr, 32'd0);
    chk("R1 sc_flag", {31'd0, sc_flag}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    op(1, 2, 0, 32'h0, 16'h0, 32'h11);            // R4 unarmed SC at reset address fails
    op(1, 1, 0, 32'h100, 16'h0, 0);               // R2
    op(1, 2, 0, 32'h100, 16'h0, 32'hCAFE0001);    // R4/R5 success
    op(1, 2, 0, 32'h100, 16'h0, 32'hCAFE0002);    // R6 second SC fails
    op(1, 1, 0, 32'h300, 16'hFFFC, 0);            // R3 negative offset -> 0x2FC
    op(0, 1, 0, 32'h500, 16'h0, 0);               // R10 strobe low ignored
    op(1, 0, 0, 32'h500, 16'h0, 0);               // R10 kind 0 ignored
    op(1, 3, 0, 32'h2F0, 16'h0F, 32'h1);          // R7 byte store 0x2FF hits word
    op(1, 1, 0, 32'h2FC, 16'h0, 0);               // R2 rearm right after cancel
    op(1, 3, 1, 32'h300, 16'h2, 32'h2);           // R7/R8 half store next word keeps
    op(1, 3, 2, 32'h2F8, 16'h0, 32'h3);           // R8 word store miss
    op(1, 2, 0, 32'h2FC, 16'h0, 32'h4);           // R4 success
    op(1, 1, 0, 32'h400, 16'h0, 0);
    op(1, 2, 0, 32'h404, 16'h0, 32'h5);           // R4 address mismatch fails, R6
    op(1, 3, 3, 32'h400, 16'h0, 32'h6);           // R9 flag holds
    op(1, 1, 0, 32'h102, 16'h0, 0);
    op(1, 3, 1, 32'h100, 16'h2, 32'h7);           // R7 masked compare vs unaligned reservation
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] k;
      k = 2'($urandom_range(0, 3));
      op($urandom_range(0, 7) != 0, k, 2'($urandom_range(0, 3)),
         32'h1000 + 32'($urandom_range(0, 3) * 4),
         16'($signed($urandom_range(0, 16)) - 8), $urandom);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule